// File: doc/BRIEF.md
# Packed SIMD Immediate Right-Shifter

This block is a lane-parallel right-shift datapath for a 128-bit vector register file. One 7-bit shift immediate, split into a 4-bit upper field and a 3-bit lower field, sets both the lane width and the shift distance. A quadword select bit picks a 64-bit or a 128-bit vector. A scalar select bit picks a single 64-bit lane.

Every active lane is widened by zero or sign extension and can be rounded. It is then shifted right, and the result can be added onto the matching lane of the old destination vector. Encodings that the block does not handle, or that are illegal, raise a flag and produce a zero result.

The result is registered once. The output strobe follows the input strobe by one cycle.

Top module: `vshr_imm`

## Requirements
- R1: The lane width comes from the highest set bit of the upper field `imm_hi`. Bit 3 gives 64, bit 2 gives 32, bit 1 gives 16 and bit 0 gives 8. In scalar mode the lane width is always 64 and there is one lane.
- R2: The shift distance is twice the lane width minus the unsigned value of `{imm_hi, imm_lo}`, so it lies between 1 and the lane width.
- R3: With `quad`=0 the active width is 64 bits, and with `quad`=1 it is 128 bits. With `quad`=0, or in scalar mode, result bits 127:64 are zero.
- R4: An `imm_hi` of 0000 raises `illegal`.
- R5: Outside scalar mode, a 64-bit lane width with `quad`=0 raises `illegal`.
- R6: In scalar mode, `imm_hi[3]`=0 raises `illegal`. The value of `quad` has no effect in scalar mode.
- R7: `uns`=1 zero-extends each lane before the shift. `uns`=0 sign-extends it.
- R8: With `rnd`=0 the bits shifted out are discarded, which truncates the result toward minus infinity.
- R9: With `rnd`=1 the value 2^(shift-1) is added to the extended lane before the shift, and no carry is lost.
- R10: With `acc`=1 each output lane is the old destination lane plus the shifted lane, modulo 2^width. With `acc`=0 the old destination lane is ignored.
- R11: `out_valid` equals `in_valid` of the previous cycle. After reset, `out_valid` and `result` are zero.
- R12: When `illegal` is raised, `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 128 | Source vector |
| dst_old | input | 128 | Old destination vector, used as the accumulate base |
| imm_hi | input | 4 | Upper immediate field |
| imm_lo | input | 3 | Lower immediate field |
| quad | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| scalar | input | 1 | Single 64-bit lane mode |
| uns | input | 1 | 1 = zero extension, 0 = sign extension |
| rnd | input | 1 | Rounding enable |
| acc | input | 1 | Accumulate enable |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Shifted vector |
| illegal | output | 1 | Encoding not handled or illegal |

## Verification
A wrong lane-size or shift decode changes the lane boundaries and values in `result` on the cycle right after the strobe. Every immediate value is swept under every control combination, so each decode path is visible. An extension or rounding error appears as a one-off or sign-fill difference in single lanes. Patterns that set lane top bits and low-order bits expose it. A stale output register shows up as a mismatch between `out_valid` and the strobe, or as nonzero upper bits in 64-bit mode.

// File: rtl/vshr_imm.sv
module vshr_imm #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] src,
  input  logic [VW-1:0] dst_old,
  input  logic [3:0]    imm_hi,
  input  logic [2:0]    imm_lo,
  input  logic          quad,
  input  logic          scalar,
  input  logic          uns,
  input  logic          rnd,
  input  logic          acc,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          illegal
);
  localparam int HALF = VW / 2;

  logic [1:0]    gsel;
  logic [7:0]    esz;
  logic [7:0]    sh;
  logic          bad;
  logic [VW-1:0] rset [4];
  logic [VW-1:0] pick;

  always_comb begin
    if (scalar || imm_hi[3]) gsel = 2'd3;
    else if (imm_hi[2])      gsel = 2'd2;
    else if (imm_hi[1])      gsel = 2'd1;
    else                     gsel = 2'd0;
  end

  assign esz  = 8'd8 << gsel;
  assign sh   = (esz << 1) - {1'b0, imm_hi, imm_lo};
  assign bad  = (imm_hi == 4'd0) || (scalar ? !imm_hi[3] : (imm_hi[3] && !quad));

  for (genvar g = 0; g < 4; g++) begin : gsz
    localparam int W = 8 << g;
    localparam int N = VW / W;
    for (genvar e = 0; e < N; e++) begin : gln
      logic signed [W+1:0] x, rc, s, t;
      logic        [W-1:0] base;
      assign x    = {{2{~uns & src[e*W+W-1]}}, src[e*W +: W]};
      assign rc   = rnd ? ((W+2)'(1) << (sh - 8'd1)) : '0;
      assign s    = x + rc;
      assign t    = s >>> sh;
      assign base = acc ? dst_old[e*W +: W] : '0;
      assign rset[g][e*W +: W] = t[W-1:0] + base;
    end
  end

  assign pick = rset[gsel] & ((quad && !scalar) ? {VW{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal <= bad;
        result  <= bad ? '0 : pick;
      end
    end
  end
endmodule

// File: rtl/vshr_imm_chk.sv
module vshr_imm_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    imm_hi,
  input logic          quad,
  input logic          scalar,
  input logic          out_valid,
  input logic [VW-1:0] result,
  input logic          illegal
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));
  a_r4_zero_hi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_hi == 4'd0) |=> illegal);
  a_r5_d64_half_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar && imm_hi[3] && !quad) |=> illegal);
  a_r6_scalar_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && !imm_hi[3]) |=> illegal);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!quad || scalar)) |=> (result[VW-1:VW/2] == '0));
endmodule

bind vshr_imm vshr_imm_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_hi(imm_hi),
  .quad(quad), .scalar(scalar), .out_valid(out_valid), .result(result),
  .illegal(illegal)
);

// File: tb/sim_vshr_imm.sv
`timescale 1ns/1ps
module sim_vshr_imm;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [127:0] src = '0, dst_old = '0;
  logic [3:0] imm_hi = '0;
  logic [2:0] imm_lo = '0;
  logic quad = 0, scalar = 0, uns = 0, rnd = 0, acc = 0;
  logic out_valid, illegal;
  logic [127:0] result;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  vshr_imm u0 (.clk, .rst_n, .in_valid, .src, .dst_old, .imm_hi, .imm_lo,
               .quad, .scalar, .uns, .rnd, .acc, .out_valid, .result, .illegal);

  function automatic logic [127:0] model(input logic [127:0] s, d, input logic [3:0] h,
      input logic [2:0] l, input logic q, sc, u, r, a, output logic ill);
    int w, sh, n;
    logic [127:0] res, mask;
    res = '0;
    ill = (h == 0) || (sc ? !h[3] : (h[3] && !q));
    if (ill) return '0;
    w = sc ? 64 : h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
    sh = 2*w - int'({h, l});
    n = sc ? 1 : (q ? 128 : 64) / w;
    mask = (128'd1 << w) - 1;
    for (int e = 0; e < n; e++) begin
      logic [127:0] v, dl;
      logic signed [71:0] x, y;
      v  = (s >> (e*w)) & mask;
      dl = (d >> (e*w)) & mask;
      x  = $signed({8'd0, v[63:0]});
      if (!u && v[w-1]) x = x - (72'sd1 <<< w);
      if (r) x = x + (72'sd1 <<< (sh-1));
      y = x >>> sh;
      if (a) y = y + $signed({8'd0, dl[63:0]});
      res |= ((128'(y)) & mask) << (e*w);
    end
    return res;
  endfunction

  function automatic string tag(input logic [3:0] h, input logic q, sc, r, a);
    if (h == 0) return "R4";
    if (sc) return h[3] ? "R6 R1 R2" : "R6";
    if (h[3] && !q) return "R5";
    if (a) return "R10 R2";
    if (r) return "R9 R1";
    if (!q) return "R3 R8";
    return "R7 R8 R2";
  endfunction

  task automatic check(input bit ok, input string t, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] s, d, input logic [3:0] h, input logic [2:0] l,
                        input logic q, sc, u, r, a);
    logic [127:0] exp;
    logic eill;
    @(negedge clk);
    src = s; dst_old = d; imm_hi = h; imm_lo = l; quad = q; scalar = sc;
    uns = u; rnd = r; acc = a; in_valid = 1'b1;
    exp = model(s, d, h, l, q, sc, u, r, a, eill);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R11 valid", {127'd0, out_valid}, 128'd1);
    check(illegal == eill && result == exp, tag(h, q, sc, r, a), result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] pats [4];
    logic [127:0] dpat;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R11 reset", result, '0);
    rst_n = 1'b1;
    pats[0] = {128{1'b1}};
    pats[1] = {16{8'h81}};
    pats[2] = {$urandom, $urandom, $urandom, $urandom};
    pats[3] = {8{16'h7fc0}};
    dpat = {$urandom, $urandom, $urandom, $urandom};
    for (int p = 0; p < 4; p++)
      for (int im = 0; im < 128; im++)
        for (int c = 0; c < 32; c++)
          run_op(pats[p], dpat, 4'(im >> 3), 3'(im), c[0], c[1], c[2], c[3], c[4]);
    // R10: the old destination is ignored when accumulate is off
    run_op(pats[2], {128{1'b1}}, 4'b0001, 3'd4, 1, 0, 1, 0, 0);
    // R11: idle cycle drops the strobe
    @(negedge clk);
    check(out_valid == 1'b0, "R11 idle", {127'd0, out_valid}, '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule